// File: doc/BRIEF.md
# Immediate Operand Generator

This block turns a 32-bit instruction word into the 64-bit immediate operand that an execution stage consumes as its second source. A 4-bit select code, produced by an upstream opcode decoder, says which immediate layout the instruction uses. The block pulls the matching bit field out of the word and left-shifts it. It then sign-extends or zero-extends the result, or substitutes a fixed all-ones constant.

The block is purely combinational and has no clock and no state. Alongside the value it raises a valid flag. The flag is low when the second operand comes from a general register or a special register, or when there is no second operand at all. In that case the value is forced to zero, so downstream muxes never see stray bits. The select code is a closed set. A code outside it is a decoder bug and raises an error in simulation.

Bit numbering is little-endian throughout: bit 0 is the least significant bit of the instruction word.

Top module: `imm_operand_gen`

## Requirements
- R1: Select codes 0 (no operand), 1 (register B) and 2 (special register) drive `imm_valid_o` low and `imm_o` to zero, whatever the instruction word.
- R2: Select 3 (unsigned half) drives `imm_o` with instr[15:0] zero-extended to 64 bits.
- R3: Select 4 (signed half) drives `imm_o` with instr[15:0] sign-extended from bit 15 to 64 bits.
- R4: Select 5 (unsigned half, high) drives `imm_o` with instr[15:0] placed at bits 31:16, and all other bits zero.
- R5: Select 6 (signed half, high) places instr[15:0] at bits 31:16 with zeros below. It then sign-extends that 32-bit value to 64 bits, so bits 63:32 copy instr[15].
- R6: Select 7 (long branch offset) drives `imm_o` with instr[25:2] shifted left by two, so bits 25:2 carry that field and every other bit is zero.
- R7: Select 8 (conditional branch offset) and select 9 (word displacement) each drive `imm_o` with instr[15:2] shifted left by two, zero-extended.
- R8: Select 10 drives `imm_o` to all ones.
- R9: Select 11 (6-bit shift amount) drives bits 4:0 from instr[15:11] and bit 5 from instr[1]; bits 63:6 are zero.
- R10: Select 12 (5-bit shift amount) drives bits 4:0 from instr[15:11]; bits 63:5 are zero.
- R11: `imm_valid_o` is high for every select from 3 to 12. Codes 13 to 15 are illegal and raise a simulation error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word, bit 0 least significant |
| sel_i | input | 4 | Second-operand select code (0 to 12 legal) |
| imm_o | output | 64 | Formed immediate operand, zero when not valid |
| imm_valid_o | output | 1 | High when `imm_o` carries an immediate |

## Verification
The bench builds the block with its default widths: a 64-bit operand and a 32-bit instruction word. At these widths the sign-fill paths run the full 48 or 32 upper bits. The split 6-bit shift field also keeps its distant top bit. Hand-computed vectors cover several corner cases: negative signed halves, the signed-high form with bit 15 set, long and conditional offsets with every field bit set, and shift fields whose stray bits are all ones. Every legal select code is then run with many random instruction words against an independent reference model.

// File: rtl/immgen_pkg.sv
// Package: shared widths, select encoding and the extracted-field bundle
// for the immediate operand generator. Assumes little-endian bit numbering.
package immgen_pkg;

    localparam int XLEN  = 64;   // operand width
    localparam int ILEN  = 32;   // instruction word width
    localparam int SEL_W = 4;    // select code width

    // Field widths and positions inside the instruction word
    localparam int HALF_W     = 16;
    localparam int HALF_LSB   = 0;
    localparam int LONG_W     = 24;
    localparam int LONG_LSB   = 2;
    localparam int COND_W     = 14;
    localparam int COND_LSB   = 2;
    localparam int SH5_W      = 5;
    localparam int SH5_LSB    = 11;
    localparam int SH_TOP_BIT = 1;
    localparam int SH6_W      = SH5_W + 1;
    localparam int WORD_SHIFT = 2;
    localparam int HIGH_SHIFT = 16;

    // Second-operand select codes (values are fixed by the upstream decoder)
    typedef enum logic [SEL_W-1:0] {
        IMM_NONE        = 4'd0,
        IMM_REGB        = 4'd1,
        IMM_SPREG       = 4'd2,
        IMM_U16         = 4'd3,
        IMM_S16         = 4'd4,
        IMM_U16_HI      = 4'd5,
        IMM_S16_HI      = 4'd6,
        IMM_BRANCH_LONG = 4'd7,
        IMM_BRANCH_COND = 4'd8,
        IMM_DISP_WORD   = 4'd9,
        IMM_ALL_ONES    = 4'd10,
        IMM_SHIFT6      = 4'd11,
        IMM_SHIFT5      = 4'd12
    } imm_sel_e;

    localparam logic [SEL_W-1:0] SEL_LAST = 4'd12;

    // Raw fields pulled out of one instruction word
    typedef struct packed {
        logic [HALF_W-1:0] half;
        logic [LONG_W-1:0] long_off;
        logic [COND_W-1:0] cond_off;
        logic [SH6_W-1:0]  sh6;
        logic [SH5_W-1:0]  sh5;
    } imm_fields_t;

endpackage

// File: rtl/imm_field_extract.sv
// Module: imm_field_extract
// Slices every immediate-bearing field out of the instruction word in one
// place, so that field positions live in a single module.
// Assumes: little-endian bit numbering; bits outside any field are ignored.
module imm_field_extract
    import immgen_pkg::*;
(
    input  logic [ILEN-1:0] instr_i,
    output imm_fields_t     fields_o
);

    // Purpose: route each field to its slot in the bundle
    always_comb begin
        fields_o.half     = instr_i[HALF_LSB +: HALF_W];
        fields_o.long_off = instr_i[LONG_LSB +: LONG_W];
        fields_o.cond_off = instr_i[COND_LSB +: COND_W];
        fields_o.sh5      = instr_i[SH5_LSB +: SH5_W];
        // The shift amount's top bit sits far from its low five bits
        fields_o.sh6      = {instr_i[SH_TOP_BIT], instr_i[SH5_LSB +: SH5_W]};
    end

    // Bits that no immediate form reads
    logic unused_bits;
    assign unused_bits = ^{instr_i[ILEN-1:LONG_LSB+LONG_W], instr_i[0]};

endmodule

// File: rtl/imm_shape.sv
// Module: imm_shape
// Places a FW-bit field at bit SHIFT of an XLEN-bit word and fills the bits
// above it. SIGNED picks sign fill from the field's top bit, else zero fill.
// Assumes: FW + SHIFT <= XLEN.
module imm_shape #(
    parameter int XLEN   = 64,
    parameter int FW     = 16,
    parameter int SHIFT  = 0,
    parameter bit SIGNED = 1'b0
) (
    input  logic [FW-1:0]   field_i,
    output logic [XLEN-1:0] value_o
);

    localparam int SPAN = FW + SHIFT;

    logic [XLEN-1:0] placed;

    // Purpose: move the field to its final position with zeros around it
    assign placed = XLEN'(field_i) << SHIFT;

    generate
        if (SIGNED) begin : g_sign_fill
            // Purpose: copy the field's top bit into every bit above the span
            always_comb begin
                value_o = placed;
                for (int b = SPAN; b < XLEN; b++) begin
                    value_o[b] = field_i[FW-1];
                end
            end
        end else begin : g_zero_fill
            assign value_o = placed;
        end
    endgenerate

endmodule

// File: rtl/imm_operand_gen.sv
// Module: imm_operand_gen (top)
// Forms the 64-bit immediate operand selected by sel_i from instr_i and
// flags whether it is valid. Purely combinational.
// Assumes: sel_i only carries codes 0..12; other codes are a decoder bug.
module imm_operand_gen
    import immgen_pkg::*;
(
    input  logic [31:0] instr_i,
    input  logic [3:0]  sel_i,
    output logic [63:0] imm_o,
    output logic        imm_valid_o
);

    imm_fields_t     fields;
    logic [XLEN-1:0] v_u16, v_s16, v_u16hi, v_s16hi;
    logic [XLEN-1:0] v_long, v_cond, v_sh6, v_sh5;

    imm_field_extract u_extract (
        .instr_i  (instr_i),
        .fields_o (fields)
    );

    imm_shape #(.XLEN(XLEN), .FW(HALF_W), .SHIFT(0), .SIGNED(1'b0)) u_u16 (
        .field_i (fields.half), .value_o (v_u16));

    imm_shape #(.XLEN(XLEN), .FW(HALF_W), .SHIFT(0), .SIGNED(1'b1)) u_s16 (
        .field_i (fields.half), .value_o (v_s16));

    imm_shape #(.XLEN(XLEN), .FW(HALF_W), .SHIFT(HIGH_SHIFT), .SIGNED(1'b0)) u_u16hi (
        .field_i (fields.half), .value_o (v_u16hi));

    imm_shape #(.XLEN(XLEN), .FW(HALF_W), .SHIFT(HIGH_SHIFT), .SIGNED(1'b1)) u_s16hi (
        .field_i (fields.half), .value_o (v_s16hi));

    imm_shape #(.XLEN(XLEN), .FW(LONG_W), .SHIFT(WORD_SHIFT), .SIGNED(1'b0)) u_long (
        .field_i (fields.long_off), .value_o (v_long));

    // Conditional offset and word displacement share one field and one shape
    imm_shape #(.XLEN(XLEN), .FW(COND_W), .SHIFT(WORD_SHIFT), .SIGNED(1'b0)) u_cond (
        .field_i (fields.cond_off), .value_o (v_cond));

    imm_shape #(.XLEN(XLEN), .FW(SH6_W), .SHIFT(0), .SIGNED(1'b0)) u_sh6 (
        .field_i (fields.sh6), .value_o (v_sh6));

    imm_shape #(.XLEN(XLEN), .FW(SH5_W), .SHIFT(0), .SIGNED(1'b0)) u_sh5 (
        .field_i (fields.sh5), .value_o (v_sh5));

    // Purpose: pick the shaped value and the valid flag for the select code
    always_comb begin
        imm_o       = '0;
        imm_valid_o = 1'b1;
        case (imm_sel_e'(sel_i))
            IMM_U16:         imm_o = v_u16;
            IMM_S16:         imm_o = v_s16;
            IMM_U16_HI:      imm_o = v_u16hi;
            IMM_S16_HI:      imm_o = v_s16hi;
            IMM_BRANCH_LONG: imm_o = v_long;
            IMM_BRANCH_COND: imm_o = v_cond;
            IMM_DISP_WORD:   imm_o = v_cond;
            IMM_ALL_ONES:    imm_o = '1;
            IMM_SHIFT6:      imm_o = v_sh6;
            IMM_SHIFT5:      imm_o = v_sh5;
            default:         imm_valid_o = 1'b0;
        endcase
    end

    // Purpose: guard the output contract and the legal select range
    always_comb begin
        AST_SEL_KNOWN: assert (sel_i <= SEL_LAST)
            else $error("illegal immediate select code %0d", sel_i); // R11
        AST_VALID_RANGE: assert (imm_valid_o == (sel_i >= 4'd3 && sel_i <= SEL_LAST)); // R11
        AST_INVALID_ZERO: assert (imm_valid_o || imm_o == '0); // R1
        if (sel_i == 4'd10) begin
            AST_ALL_ONES: assert (&imm_o); // R8
        end
        if (sel_i == 4'd4) begin
            AST_S16_FILL: assert (imm_o[XLEN-1:HALF_W] == {(XLEN-HALF_W){instr_i[15]}}); // R3
        end
        if (sel_i == 4'd6) begin
            AST_S16HI_LOW_ZERO: assert (imm_o[HIGH_SHIFT-1:0] == '0); // R5
        end
        if (sel_i == 4'd11) begin
            AST_SH6_TOP: assert (imm_o[5] == instr_i[1] && imm_o[XLEN-1:SH6_W] == '0); // R9
        end
    end

endmodule

// File: tb/imm_operand_gen_tb.sv
// Bench for imm_operand_gen: vector table, then random sweep of every legal
// select against a reference model, then directed corner cases.
module imm_operand_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr;
    logic [3:0]  sel;
    logic [63:0] imm;
    logic        vld;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    imm_operand_gen u_dut (
        .instr_i     (instr),
        .sel_i       (sel),
        .imm_o       (imm),
        .imm_valid_o (vld)
    );

    typedef struct packed {
        logic [3:0]  sel;
        logic [31:0] instr;
        logic [63:0] imm;
        logic        vld;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{4'd0,  32'hFFFF_FFFF, 64'h0,                    1'b0},
        '{4'd1,  32'hFFFF_FFFF, 64'h0,                    1'b0},
        '{4'd2,  32'hFFFF_FFFF, 64'h0,                    1'b0},
        '{4'd3,  32'hFFFF_FFFF, 64'h0000_0000_0000_FFFF, 1'b1},
        '{4'd4,  32'h0000_8000, 64'hFFFF_FFFF_FFFF_8000, 1'b1},
        '{4'd4,  32'h1234_7FFF, 64'h0000_0000_0000_7FFF, 1'b1},
        '{4'd5,  32'h0000_8001, 64'h0000_0000_8001_0000, 1'b1},
        '{4'd6,  32'h0000_8001, 64'hFFFF_FFFF_8001_0000, 1'b1},
        '{4'd7,  32'hFFFF_FFFF, 64'h0000_0000_03FF_FFFC, 1'b1},
        '{4'd8,  32'hFFFF_FFFF, 64'h0000_0000_0000_FFFC, 1'b1},
        '{4'd9,  32'hFFFF_FFFF, 64'h0000_0000_0000_FFFC, 1'b1},
        '{4'd10, 32'h0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1},
        '{4'd11, 32'h0000_F802, 64'h0000_0000_0000_003F, 1'b1},
        '{4'd11, 32'h0000_0002, 64'h0000_0000_0000_0020, 1'b1},
        '{4'd11, 32'hFFFF_07FD, 64'h0000_0000_0000_0000, 1'b1},
        '{4'd12, 32'hFFFF_FFFF, 64'h0000_0000_0000_001F, 1'b1}
    };

    // Requirement tag that covers each select code
    function automatic string req_of(input logic [3:0] s);
        case (s)
            4'd0, 4'd1, 4'd2: return "R1";
            4'd3:  return "R2";
            4'd4:  return "R3";
            4'd5:  return "R4";
            4'd6:  return "R5";
            4'd7:  return "R6";
            4'd8, 4'd9: return "R7";
            4'd10: return "R8";
            4'd11: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Reference model written from the requirements
    function automatic logic [64:0] model(input logic [3:0] s, input logic [31:0] w);
        logic [63:0] v;
        logic        ok;
        ok = 1'b1;
        case (s)
            4'd3:  v = {48'h0, w[15:0]};                           // R2
            4'd4:  v = {{48{w[15]}}, w[15:0]};                     // R3
            4'd5:  v = {32'h0, w[15:0], 16'h0};                    // R4
            4'd6:  v = {{32{w[15]}}, w[15:0], 16'h0};              // R5
            4'd7:  v = {38'h0, w[25:2], 2'b00};                    // R6
            4'd8, 4'd9: v = {48'h0, w[15:2], 2'b00};               // R7
            4'd10: v = {64{1'b1}};                                 // R8
            4'd11: v = {58'h0, w[1], w[15:11]};                    // R9
            4'd12: v = {59'h0, w[15:11]};                          // R10
            default: begin v = 64'h0; ok = 1'b0; end               // R1
        endcase
        return {ok, v};
    endfunction

    task automatic check(input string req, input logic [63:0] exp_v, input logic exp_ok);
        n_tests++;
        if (imm !== exp_v || vld !== exp_ok) begin
            n_fail++;
            $display("FAIL %s sel=%0d instr=%h: imm=%h valid=%b, expected imm=%h valid=%b",
                     req, sel, instr, imm, vld, exp_v, exp_ok);
        end
    endtask

    task automatic apply(input logic [3:0] s, input logic [31:0] w);
        @(negedge clk);
        sel   = s;
        instr = w;
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [64:0] r;
        sel   = 4'd0;
        instr = 32'hDEAD_BEEF;
        repeat (3) @(posedge clk);
        #1;
        check("R1", 64'h0, 1'b0);     // idle state under reset: no operand
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].sel, VECS[i].instr);
            check(req_of(VECS[i].sel), VECS[i].imm, VECS[i].vld);
        end

        // Random sweep of every legal select (R11 validity included)
        for (int s = 0; s <= 12; s++) begin
            for (int k = 0; k < 200; k++) begin
                apply(4'(s), $urandom());
                r = model(sel, instr);
                check(s >= 3 ? "R11" : req_of(sel), r[63:0], r[64]);
            end
        end

        // Directed corners
        apply(4'd3, 32'h0000_8000); check("R2", 64'h0000_0000_0000_8000, 1'b1);
        apply(4'd5, 32'hFFFF_FFFF); check("R4", 64'h0000_0000_FFFF_0000, 1'b1);
        apply(4'd6, 32'h0000_7FFF); check("R5", 64'h0000_0000_7FFF_0000, 1'b1);
        apply(4'd7, 32'hFC00_0003); check("R6", 64'h0, 1'b1);
        apply(4'd9, 32'hFFFF_0003); check("R7", 64'h0, 1'b1);
        apply(4'd12, 32'h0000_0002); check("R10", 64'h0, 1'b1);
        apply(4'd1, 32'h0000_8000); check("R1", 64'h0, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule